// File: doc/BRIEF.md
# PWM Brake Input Conditioner

This block turns two raw fault sources into clean, latched brake requests for a PWM unit. Each brake path takes a level in which high means idle and low means fault. The level passes through an optional noise filter and then a falling-edge detector. A detected edge on an enabled path sets a sticky flag. The flag holds the path in its brake state until software clears the flag by writing 1 to it.

Brake 0 takes the external pin 0, which can be inverted. Any of three comparator outputs can also trip brake 0, and each comparator has its own enable. Brake 1 takes one source chosen by a 2-bit select: the external pin 1 or one of the three comparator outputs. A low-voltage detect input, when enabled, can also trip brake 1. A comparator output or the low-voltage detect input trips a brake when it is high. The noise filter samples at the system clock divided by 1, 2, 4 or 16. It changes its output only when three samples in a row agree, and it can be bypassed.

Top module: `pwm_brake_cond`

## Requirements
- R1: When `inv_pin[i]` is 1, the pin level used for brake i is inverted before it reaches the filter and the edge detector. A rising edge on the raw pin then trips the brake.
- R2: The filter sampling strobe uses a free-running 4-bit prescaler that starts at 0 at reset. The select value 0 strobes every cycle. The value 1 strobes when prescaler bit 0 is 0, the value 2 when bits 1:0 are 0, and the value 3 when all four bits are 0.
- R3: With the filter enabled, the filtered level takes a new value only on a strobe where that strobe's sample and the two samples before it are all equal. A low pulse that spans fewer than three strobes never sets a flag.
- R4: When `filt_bypass[i]` is 1, the filter is skipped. A falling edge at the input then sets the flag at the next clock edge.
- R5: The brake 1 source select `b1_src` works as follows: 00 takes the pin (after inversion), and 01, 10 and 11 take comparator 0, 1 and 2. For a comparator source, an output of 1 is a fault.
- R6: `cmp_b0_en[k]` lets comparator k pull brake 0 into fault when its output is 1. These sources are OR-combined with the pin.
- R7: When `lvd_b1_en` is 1, `lvd_in` = 1 forces brake 1 into fault. This input is OR-combined with the selected source.
- R8: Only a falling edge of the conditioned level, seen while `brk_en[i]` is 1, sets `flag[i]`. Rising edges, and edges seen while the path is disabled, leave the flag unchanged.
- R9: An edge that sets `flag[0]` also sets `lock0`. `lock0` is cleared only by a pulse on `clr_lock`.
- R10: A pulse on `clr_flag[i]` clears `flag[i]` at the next clock edge. If a new set arrives in the same cycle, the set wins.
- R11: `brk_state[i]` is high while `flag[i]` is set. It drops in the cycle after the clearing write.
- R12: `irq` is high exactly when `irq_en` is 1 and at least one brake flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| brk_pin | input | 2 | Raw brake pins 0 and 1, idle high |
| cmp_out | input | 3 | Comparator digital outputs 0..2 |
| lvd_in | input | 1 | Low-voltage detect event |
| inv_pin | input | 2 | Per-pin inversion |
| filt_sel0 | input | 2 | Filter rate select, brake 0 |
| filt_sel1 | input | 2 | Filter rate select, brake 1 |
| filt_bypass | input | 2 | Per-path filter bypass |
| b1_src | input | 2 | Brake 1 source select |
| cmp_b0_en | input | 3 | Comparator enables for brake 0 |
| lvd_b1_en | input | 1 | Low-voltage detect enable for brake 1 |
| brk_en | input | 2 | Per-path brake enable |
| irq_en | input | 1 | Brake interrupt enable |
| clr_flag | input | 2 | Write-1 clear pulses for the brake flags |
| clr_lock | input | 1 | Write-1 clear pulse for the lock flag |
| flag | output | 2 | Sticky brake flags |
| lock0 | output | 1 | Brake 0 lock flag |
| brk_state | output | 2 | Live brake state per path |
| irq | output | 1 | Brake interrupt request |

## Verification
A wrong sample history or prescaler phase does not show up at once. It shows up as a flag that rises one or more strobes early or late, or not at all. At the slowest rate that can be tens of cycles after the input edge. A stale edge-detector register shows up as a missing or spurious flag on the first edge after a configuration change. For this reason the bench compares every output against a cycle model on every cycle, not only at the end of a scenario. A fault in the flag logic shows up within one cycle on `flag`, `brk_state` and `irq` together.

// File: rtl/pwm_brake_cond.sv
module pwm_brake_cond #(
  parameter int NPATH = 2,
  parameter int NCMP  = 3,
  parameter int PSW   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPATH-1:0] brk_pin,
  input  logic [NCMP-1:0]  cmp_out,
  input  logic             lvd_in,
  input  logic [NPATH-1:0] inv_pin,
  input  logic [1:0]       filt_sel0,
  input  logic [1:0]       filt_sel1,
  input  logic [NPATH-1:0] filt_bypass,
  input  logic [1:0]       b1_src,
  input  logic [NCMP-1:0]  cmp_b0_en,
  input  logic             lvd_b1_en,
  input  logic [NPATH-1:0] brk_en,
  input  logic             irq_en,
  input  logic [NPATH-1:0] clr_flag,
  input  logic             clr_lock,
  output logic [NPATH-1:0] flag,
  output logic             lock0,
  output logic [NPATH-1:0] brk_state,
  output logic             irq
);
  logic [PSW-1:0]   pre_cnt;
  logic [NPATH-1:0] pin_lvl, raw, lvl, fall;
  logic             src1;
  logic [1:0]       fsel [NPATH];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pre_cnt <= '0;
    else        pre_cnt <= pre_cnt + 1'b1;

  assign pin_lvl = brk_pin ^ inv_pin;
  assign fsel[0] = filt_sel0;
  assign fsel[1] = filt_sel1;

  always_comb begin
    case (b1_src)
      2'd0:    src1 = pin_lvl[1];
      2'd1:    src1 = ~cmp_out[0];
      2'd2:    src1 = ~cmp_out[1];
      default: src1 = ~cmp_out[2];
    endcase
  end

  assign raw[0] = pin_lvl[0] & ~|(cmp_out & cmp_b0_en);
  assign raw[1] = src1 & ~(lvd_in & lvd_b1_en);

  for (genvar g = 0; g < NPATH; g++) begin : g_path
    logic       tick, filt_q, prev_q;
    logic [1:0] hist;

    always_comb begin
      case (fsel[g])
        2'd0:    tick = 1'b1;
        2'd1:    tick = ~pre_cnt[0];
        2'd2:    tick = ~|pre_cnt[1:0];
        default: tick = ~|pre_cnt;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        hist   <= 2'b11;
        filt_q <= 1'b1;
      end else if (tick) begin
        hist <= {hist[0], raw[g]};
        if (hist[1] == raw[g] && hist[0] == raw[g]) filt_q <= raw[g];
      end

    assign lvl[g] = filt_bypass[g] ? raw[g] : filt_q;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= lvl[g];

    assign fall[g] = prev_q & ~lvl[g] & brk_en[g];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) flag[g] <= 1'b0;
      else        flag[g] <= (flag[g] & ~clr_flag[g]) | fall[g];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lock0 <= 1'b0;
    else        lock0 <= (lock0 & ~clr_lock) | fall[0];

  assign brk_state = flag;
  assign irq       = irq_en & |flag;
endmodule

// File: rtl/pwm_brake_cond_chk.sv
module pwm_brake_cond_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] brk_en,
  input logic       irq_en,
  input logic [1:0] clr_flag,
  input logic       clr_lock,
  input logic [1:0] flag,
  input logic       lock0,
  input logic [1:0] brk_state,
  input logic       irq
);
  assert_irq_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && flag != 2'b00));
  assert_flag0_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag[0] && !clr_flag[0]) |=> flag[0]);
  assert_flag1_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag[1] && !clr_flag[1]) |=> flag[1]);
  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lock0 && !clr_lock) |=> lock0);
  assert_lock_with_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock0) |-> flag[0]);
  assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!brk_en[1] && !flag[1]) |=> !flag[1]);
  assert_release_after_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(brk_state[0]) |-> $past(clr_flag[0]));
endmodule

bind pwm_brake_cond pwm_brake_cond_chk u_chk (
  .clk(clk), .rst_n(rst_n), .brk_en(brk_en), .irq_en(irq_en),
  .clr_flag(clr_flag), .clr_lock(clr_lock), .flag(flag), .lock0(lock0),
  .brk_state(brk_state), .irq(irq)
);

// File: tb/pwm_brake_cond_bench.sv
module pwm_brake_cond_bench;
  logic clk = 0, rst_n = 0;
  logic [1:0] brk_pin, inv_pin, filt_sel0, filt_sel1, filt_bypass, b1_src, brk_en, clr_flag;
  logic [2:0] cmp_out, cmp_b0_en;
  logic lvd_in, lvd_b1_en, irq_en, clr_lock;
  logic [1:0] flag, brk_state;
  logic lock0, irq;
  int checks = 0, fails = 0;
  string tag = "R8";

  always #10 clk = ~clk;

  pwm_brake_cond u_pwm_brake_cond (.*);

  logic [3:0] m_cnt;
  logic [1:0] m_hist [2];
  logic [1:0] m_filt, m_prev, m_flag;
  logic m_lock;

  function automatic logic strobe(input logic [1:0] s, input logic [3:0] c);
    return (s == 0) || (s == 1 && c[0] == 0) || (s == 2 && c[1:0] == 0) || (s == 3 && c == 0);
  endfunction

  function automatic logic [1:0] src_level();
    logic [1:0] r;
    logic p0, p1, s1;
    p0 = brk_pin[0] ^ inv_pin[0];
    p1 = brk_pin[1] ^ inv_pin[1];
    r[0] = p0 && !((cmp_out[0] && cmp_b0_en[0]) || (cmp_out[1] && cmp_b0_en[1]) || (cmp_out[2] && cmp_b0_en[2]));
    s1 = (b1_src == 0) ? p1 : !cmp_out[b1_src - 1];
    r[1] = s1 && !(lvd_in && lvd_b1_en);
    return r;
  endfunction

  task automatic model_reset();
    m_cnt = 0; m_hist[0] = 2'b11; m_hist[1] = 2'b11;
    m_filt = 2'b11; m_prev = 2'b11; m_flag = 0; m_lock = 0;
  endtask

  task automatic model_step();
    logic [1:0] r, l, f;
    logic [1:0] sel [2];
    sel[0] = filt_sel0; sel[1] = filt_sel1;
    r = src_level();
    for (int i = 0; i < 2; i++) begin
      l[i] = filt_bypass[i] ? r[i] : m_filt[i];
      f[i] = m_prev[i] && !l[i] && brk_en[i];
    end
    for (int i = 0; i < 2; i++) begin
      if (strobe(sel[i], m_cnt)) begin
        if (m_hist[i] == {r[i], r[i]}) m_filt[i] = r[i];
        m_hist[i] = {m_hist[i][0], r[i]};
      end
      m_flag[i] = (m_flag[i] && !clr_flag[i]) || f[i];
    end
    m_lock = (m_lock && !clr_lock) || f[0];
    m_prev = l;
    m_cnt = m_cnt + 1;
  endtask

  task automatic check(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) begin
      model_step();
      @(negedge clk);
      clr_flag = 0; clr_lock = 0;
      check({irq, lock0, brk_state, flag} == {irq_en && m_flag != 0, m_lock, m_flag, m_flag}, tag,
            {1'b0, irq, lock0, brk_state, flag}, {1'b0, irq_en && m_flag != 0, m_lock, m_flag, m_flag});
    end
  endtask

  task automatic idle_cfg();
    brk_pin = 2'b11; inv_pin = 0; filt_sel0 = 0; filt_sel1 = 0; filt_bypass = 0;
    b1_src = 0; brk_en = 2'b11; clr_flag = 0; clr_lock = 0; cmp_out = 0;
    cmp_b0_en = 0; lvd_in = 0; lvd_b1_en = 0; irq_en = 1;
  endtask

  task automatic clear_all();
    clr_flag = 2'b11; clr_lock = 1; cyc(1); cyc(8);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle_cfg();
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R12 reset";
    check({irq, lock0, flag} == 0, "R12 reset", {4'b0, irq, lock0, flag}, 8'h00);
    cyc(10);

    tag = "R3 glitch";
    brk_pin[0] = 0; cyc(2); brk_pin[0] = 1; cyc(8);
    check(flag[0] == 0, "R3 glitch rejected", {7'b0, flag[0]}, 8'h00);
    tag = "R3 long";
    brk_pin[0] = 0; cyc(6);
    check(flag[0] == 1 && lock0 == 1, "R3/R9 long low trips", {6'b0, lock0, flag[0]}, 8'h03);
    tag = "R11 release";
    clr_flag = 2'b01; cyc(1);
    check(brk_state[0] == 0, "R11 state released", {7'b0, brk_state[0]}, 8'h00);
    check(lock0 == 1, "R9 lock held", {7'b0, lock0}, 8'h01);
    brk_pin[0] = 1; clear_all();

    tag = "R4 bypass";
    filt_bypass = 2'b11; brk_pin[1] = 0; cyc(1);
    check(flag[1] == 1, "R4 bypass one cycle", {7'b0, flag[1]}, 8'h01);
    tag = "R10 set wins";
    brk_pin[1] = 1; cyc(2); brk_pin[1] = 0; clr_flag = 2'b10; cyc(1);
    check(flag[1] == 1, "R10 set beats clear", {7'b0, flag[1]}, 8'h01);
    brk_pin[1] = 1; clear_all();

    tag = "R1 invert";
    inv_pin = 2'b01; cyc(4); clear_all();
    brk_pin[0] = 0; cyc(1);
    check(flag[0] == 0, "R1 inverted fall ignored", {7'b0, flag[0]}, 8'h00);
    brk_pin[0] = 1; cyc(1);
    check(flag[0] == 1, "R1 inverted rise trips", {7'b0, flag[0]}, 8'h01);
    inv_pin = 0; cyc(3); clear_all();

    tag = "R6 cmp";
    cmp_b0_en = 3'b100; cmp_out = 3'b011; cyc(3);
    check(flag[0] == 0, "R6 disabled comparators", {7'b0, flag[0]}, 8'h00);
    cmp_out = 3'b100; cyc(1);
    check(flag[0] == 1, "R6 enabled comparator", {7'b0, flag[0]}, 8'h01);
    cmp_out = 0; cmp_b0_en = 0; cyc(2); clear_all();

    tag = "R5 select";
    b1_src = 2'd2; cmp_out = 3'b101; cyc(2);
    check(flag[1] == 0, "R5 unselected comparators", {7'b0, flag[1]}, 8'h00);
    cmp_out = 3'b010; cyc(1);
    check(flag[1] == 1, "R5 comparator 1 selected", {7'b0, flag[1]}, 8'h01);
    cmp_out = 0; b1_src = 0; cyc(2); clear_all();

    tag = "R7 lvd";
    lvd_in = 1; cyc(2);
    check(flag[1] == 0, "R7 lvd disabled", {7'b0, flag[1]}, 8'h00);
    lvd_in = 0; lvd_b1_en = 1; cyc(1); lvd_in = 1; cyc(1);
    check(flag[1] == 1, "R7 lvd trips", {7'b0, flag[1]}, 8'h01);
    lvd_in = 0; lvd_b1_en = 0; cyc(2); clear_all();

    tag = "R8 disabled";
    brk_en = 2'b01; brk_pin[1] = 0; cyc(2);
    check(flag[1] == 0 && brk_state[1] == 0, "R8 disabled path", {7'b0, flag[1]}, 8'h00);
    brk_pin[1] = 1; brk_en = 2'b11; cyc(2);
    tag = "R12 gate";
    irq_en = 0; brk_pin[0] = 0; cyc(1);
    check(irq == 0 && flag[0] == 1, "R12 irq masked", {6'b0, irq, flag[0]}, 8'h01);
    irq_en = 1; cyc(1);
    check(irq == 1, "R12 irq on", {7'b0, irq}, 8'h01);
    brk_pin[0] = 1; filt_bypass = 0; clear_all();

    tag = "R2 rate";
    filt_sel0 = 2'd3; cyc(20);
    brk_pin[0] = 0; cyc(20);
    check(flag[0] == 0, "R2 slow rate still filtering", {7'b0, flag[0]}, 8'h00);
    cyc(30);
    check(flag[0] == 1, "R2 slow rate trips", {7'b0, flag[0]}, 8'h01);
    brk_pin[0] = 1; cyc(60); clear_all();

    tag = "R2 R3 R8 R10 random";
    for (int blk = 0; blk < 40; blk++) begin
      filt_sel0 = 2'($urandom); filt_sel1 = 2'($urandom);
      filt_bypass = 2'($urandom); inv_pin = 2'($urandom);
      b1_src = 2'($urandom); cmp_b0_en = 3'($urandom);
      lvd_b1_en = 1'($urandom); brk_en = 2'($urandom) | 2'b01;
      irq_en = 1'($urandom);
      for (int s = 0; s < 25; s++) begin
        if ($urandom % 3 == 0) brk_pin = 2'($urandom);
        if ($urandom % 6 == 0) cmp_out = 3'($urandom);
        if ($urandom % 8 == 0) lvd_in = 1'($urandom);
        if ($urandom % 5 == 0) clr_flag = 2'($urandom);
        if ($urandom % 7 == 0) clr_lock = 1;
        cyc(1 + $urandom % 12);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial void'($urandom(32'h5eed));
endmodule